// File: doc/BRIEF.md
# Modem Synchronous Data Clock Generator

This block derives the serial-interface data clocks of a voiceband modem from one master clock (11.0592 MHz in the target system). The transmit clock runs in every mode. In the synchronous modulations it has one of three timing sources:

- **Internal:** a divider from the master clock.
- **External:** a divider phase-tracked to an external clock input.
- **Slave:** a divider phase-tracked to the recovered receive clock.

In the two frequency-shift modulation families the block instead drives a fixed 16x oversampling clock on both the transmit and receive clock outputs.

Tracking uses a free-running counter at the nominal divide ratio. On each synchronized rising edge of the reference, the counter is nudged by one master-clock tick toward lock. If no reference edge arrives for two nominal periods, the divider free-runs.

On the receive side the block gates everything with carrier detect:

- The receive clock and its tri-state enable are active only while a carrier is present.
- Receive data is forced to mark (1) when there is no carrier.

Mode changes are adopted only at a transmit period boundary, so the transmit clock never produces a runt pulse.

Top module: `modem_clkgen`

## Requirements
- R1: `mod_sel` selects the synchronous modulations as follows: 0 = 2400 Hz (ratio `DIV_QAM`, default 4608), 1 = 1200 Hz (`DIV_DPSK`, 9216), 2 = 600 Hz (`DIV_HALF`, 18432). Codes 6 and 7 act as 0. `tmode_sel` 0 (or 3) selects internal timing. In internal timing `tx_clk` has a period of exactly the ratio in master cycles: low for the first half and high for the second half.
- R2: `mod_sel` 3 selects 16x1200 Hz (`DIV_FAST`, 576), 4 selects 16x75 Hz (`DIV_SLOW`, 9216) and 5 selects 16x300 Hz (`DIV_MID`, 2304). In these modes `tx_clk` free-runs at that ratio whatever `tmode_sel` and the references do. While a carrier is present, `rx_clk` carries the same waveform as `tx_clk`.
- R3: With `tmode_sel` = 1 (external) and a synchronous modulation, each rising edge of `ext_clk` moves the transmit divider by at most one master tick toward the phase in which the edge is seen at mid-period: one tick is held back when the divider is ahead, and one extra tick is added when it is behind. The edge is seen three master edges after `ext_clk` rises.
- R4: With `tmode_sel` = 2 (slave), the same tracking as R3 uses `rx_clk_in` as the reference.
- R5: If no reference edge arrives for 2x the ratio master cycles, the divider runs at nominal rate. The first reference edge after such a gap causes no correction; it only re-arms tracking.
- R6: A new `mod_sel` or `tmode_sel` value takes effect only when the transmit divider wraps to the start of a period.
- R7: `rx_clk_oe` equals `carrier_det` delayed by one master cycle. `rx_clk` is 0 whenever `rx_clk_oe` is 0. In the synchronous modulations, `rx_clk` reproduces `rx_clk_in` two master cycles after the input is first sampled.
- R8: `rx_data` equals `rx_data_in` one master cycle later while a carrier is present, and is 1 (mark) otherwise.
- R9: Synchronous reset clears `tx_clk`, `rx_clk` and `rx_clk_oe`, sets `rx_data` to 1, and loads the current `mod_sel` and `tmode_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_sel | input | 3 | Modulation select (encoding in R1, R2) |
| tmode_sel | input | 2 | Transmit timing select: 0 internal, 1 external, 2 slave, 3 internal |
| ext_clk | input | 1 | External timing reference |
| rx_clk_in | input | 1 | Recovered receive clock from the demodulator |
| carrier_det | input | 1 | Carrier present flag |
| rx_data_in | input | 1 | Raw receive data from the demodulator |
| tx_clk | output | 1 | Transmit data clock |
| rx_clk | output | 1 | Receive data clock |
| rx_clk_oe | output | 1 | Tri-state enable for the receive clock |
| rx_data | output | 1 | Carrier-gated receive data |

## Verification
The result latencies are as follows:

- **Transmit clock:** `tx_clk` is registered from the divider count, so it changes on the same master edge that moves the count. A reference rise applied between edges affects the count on the third following edge.
- **Receive side:** `rx_clk_oe` and `rx_data` respond on the first edge after `carrier_det` or `rx_data_in` changes. `rx_clk` follows `rx_clk_in` on the second edge after the input is first sampled.

The bench drives inputs just after the rising edge. It keeps a behavioural model that takes in the same sampled inputs at every rising edge, with these pipeline delays counted explicitly. It compares all four outputs at the falling edge, so each comparison falls in the cycle in which the result is due.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  localparam logic [2:0] MOD_QAM  = 3'd0;
  localparam logic [2:0] MOD_DPSK = 3'd1;
  localparam logic [2:0] MOD_HALF = 3'd2;
  localparam logic [2:0] MOD_FAST = 3'd3;
  localparam logic [2:0] MOD_SLOW = 3'd4;
  localparam logic [2:0] MOD_MID  = 3'd5;

  localparam logic [1:0] TM_INT   = 2'd0;
  localparam logic [1:0] TM_EXT   = 2'd1;
  localparam logic [1:0] TM_SLAVE = 2'd2;

  function automatic logic is_fsk(input logic [2:0] m);
    return (m == MOD_FAST) || (m == MOD_SLOW) || (m == MOD_MID);
  endfunction
endpackage

// File: rtl/mclk_ref_sync.sv
module mclk_ref_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= 3'b000;
    else     sh <= {sh[1:0], din};
  end

  assign level = sh[1];
  assign rise  = sh[1] & ~sh[2];
endmodule

// File: rtl/mclk_phase_div.sv
module mclk_phase_div
  import mclk_pkg::*;
#(
  parameter int DIV_QAM  = 4608,
  parameter int DIV_DPSK = 9216,
  parameter int DIV_HALF = 18432,
  parameter int DIV_FAST = 576,
  parameter int DIV_SLOW = 9216,
  parameter int DIV_MID  = 2304
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mod_sel,
  input  logic [1:0] tmode_sel,
  input  logic       ext_rise,
  input  logic       slv_rise,
  output logic       tx_clk,
  output logic       tx_next,
  output logic       fsk_act
);
  localparam int M1   = (DIV_QAM  > DIV_DPSK) ? DIV_QAM  : DIV_DPSK;
  localparam int M2   = (DIV_HALF > DIV_FAST) ? DIV_HALF : DIV_FAST;
  localparam int M3   = (DIV_SLOW > DIV_MID)  ? DIV_SLOW : DIV_MID;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int RMAX = (M12 > M3) ? M12 : M3;
  localparam int CW   = $clog2(RMAX + 2);
  localparam int WW   = $clog2(2 * RMAX + 2);

  function automatic logic [CW-1:0] ratio_of(input logic [2:0] m);
    case (m)
      MOD_DPSK: return CW'(DIV_DPSK);
      MOD_HALF: return CW'(DIV_HALF);
      MOD_FAST: return CW'(DIV_FAST);
      MOD_SLOW: return CW'(DIV_SLOW);
      MOD_MID:  return CW'(DIV_MID);
      default:  return CW'(DIV_QAM);
    endcase
  endfunction

  logic [2:0]    mod_act;
  logic [1:0]    tm_act;
  logic [CW-1:0] cnt, nrat, half, err, nxt_c;
  logic [CW:0]   sum;
  logic [WW-1:0] watch, limit;
  logic [1:0]    step;
  logic          alive, locked, ref_rise, wrap;

  assign nrat     = ratio_of(mod_act);
  assign half     = nrat >> 1;
  assign fsk_act  = is_fsk(mod_act);
  assign locked   = !fsk_act && (tm_act == TM_EXT || tm_act == TM_SLAVE);
  assign ref_rise = (tm_act == TM_SLAVE) ? slv_rise : ext_rise;
  assign err      = (cnt >= half) ? cnt - half : cnt + half;
  assign limit    = WW'({nrat, 1'b0}) - WW'(1);

  always_comb begin
    step = 2'd1;
    if (locked && ref_rise && alive && err != '0)
      step = (err < half) ? 2'd0 : 2'd2;
  end

  assign sum     = {1'b0, cnt} + (CW+1)'(step);
  assign wrap    = sum >= {1'b0, nrat};
  assign nxt_c   = wrap ? CW'(sum - {1'b0, nrat}) : CW'(sum);
  assign tx_next = nxt_c >= half;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tx_clk  <= 1'b0;
      mod_act <= mod_sel;
      tm_act  <= tmode_sel;
      watch   <= '0;
      alive   <= 1'b0;
    end else begin
      cnt    <= nxt_c;
      tx_clk <= tx_next;
      if (wrap) begin
        mod_act <= mod_sel;
        tm_act  <= tmode_sel;
      end
      if (!locked) begin
        alive <= 1'b0;
        watch <= '0;
      end else if (ref_rise) begin
        alive <= 1'b1;
        watch <= '0;
      end else if (watch >= limit) begin
        alive <= 1'b0;
      end else begin
        watch <= watch + WW'(1);
      end
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt < nrat);

  assert_mode_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (mod_act != $past(mod_act) || tm_act != $past(tm_act)) |-> (cnt < CW'(2)));

  assert_free_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!locked && cnt != '0) |=> (cnt == '0 || cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/mclk_rx_gate.sv
module mclk_rx_gate (
  input  logic clk,
  input  logic rst,
  input  logic carrier,
  input  logic din,
  input  logic ref_level,
  input  logic fsk,
  input  logic tx_next,
  output logic rx_clk,
  output logic rx_clk_oe,
  output logic rx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_clk    <= 1'b0;
      rx_clk_oe <= 1'b0;
      rx_data   <= 1'b1;
    end else begin
      rx_clk_oe <= carrier;
      rx_data   <= carrier ? din : 1'b1;
      rx_clk    <= carrier & (fsk ? tx_next : ref_level);
    end
  end

  assert_rxclk_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !rx_clk_oe |-> !rx_clk);

  assert_rxd_mark_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_clk_oe |-> rx_data);
endmodule

// File: rtl/modem_clkgen.sv
module modem_clkgen #(
  parameter int DIV_QAM  = 4608,
  parameter int DIV_DPSK = 9216,
  parameter int DIV_HALF = 18432,
  parameter int DIV_FAST = 576,
  parameter int DIV_SLOW = 9216,
  parameter int DIV_MID  = 2304
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mod_sel,
  input  logic [1:0] tmode_sel,
  input  logic       ext_clk,
  input  logic       rx_clk_in,
  input  logic       carrier_det,
  input  logic       rx_data_in,
  output logic       tx_clk,
  output logic       rx_clk,
  output logic       rx_clk_oe,
  output logic       rx_data
);
  localparam int NREF = 2;

  logic [NREF-1:0] ref_in, ref_lvl, ref_rise;
  logic            tx_next, fsk_act;

  assign ref_in = {ext_clk, rx_clk_in};

  for (genvar i = 0; i < NREF; i++) begin : g_sync
    mclk_ref_sync u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (ref_in[i]),
      .level(ref_lvl[i]),
      .rise (ref_rise[i])
    );
  end

  mclk_phase_div #(
    .DIV_QAM(DIV_QAM), .DIV_DPSK(DIV_DPSK), .DIV_HALF(DIV_HALF),
    .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .mod_sel  (mod_sel),
    .tmode_sel(tmode_sel),
    .ext_rise (ref_rise[1]),
    .slv_rise (ref_rise[0]),
    .tx_clk   (tx_clk),
    .tx_next  (tx_next),
    .fsk_act  (fsk_act)
  );

  mclk_rx_gate u_rx (
    .clk      (clk),
    .rst      (rst),
    .carrier  (carrier_det),
    .din      (rx_data_in),
    .ref_level(ref_lvl[0]),
    .fsk      (fsk_act),
    .tx_next  (tx_next),
    .rx_clk   (rx_clk),
    .rx_clk_oe(rx_clk_oe),
    .rx_data  (rx_data)
  );
endmodule

// File: tb/modem_clkgen_tb.sv
`timescale 1ns/1ps
module modem_clkgen_tb;
  localparam int RQ = 16, RD = 32, RH = 64, RF = 8, RS = 32, RM = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mod_sel = 3'd0;
  logic [1:0] tmode_sel = 2'd0;
  logic       ext_clk = 1'b0, rx_clk_in = 1'b0, carrier_det = 1'b0, rx_data_in = 1'b0;
  logic       tx_clk, rx_clk, rx_clk_oe, rx_data;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // reference generator configuration
  int  g_per = 16, g_ph = 0;
  bit  g_en = 0, g_to_ext = 1;

  modem_clkgen #(.DIV_QAM(RQ), .DIV_DPSK(RD), .DIV_HALF(RH),
                 .DIV_FAST(RF), .DIV_SLOW(RS), .DIV_MID(RM)) u_dut (
    .clk(clk), .rst(rst), .mod_sel(mod_sel), .tmode_sel(tmode_sel),
    .ext_clk(ext_clk), .rx_clk_in(rx_clk_in), .carrier_det(carrier_det),
    .rx_data_in(rx_data_in), .tx_clk(tx_clk), .rx_clk(rx_clk),
    .rx_clk_oe(rx_clk_oe), .rx_data(rx_data));

  always #10 clk = ~clk;

  // behavioural reference model
  int m_cnt, m_tx, m_mod, m_tm, m_watch, m_alive, m_rxclk, m_oe, m_rxd;
  int n, h, stp, er, nc;
  bit fsk, lk, e, wr;
  bit se[3], sr[3];

  function automatic int rat(input int m);
    case (m)
      1: return RD; 2: return RH; 3: return RF; 4: return RS; 5: return RM;
      default: return RQ;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0; m_tx = 0; m_mod = mod_sel; m_tm = tmode_sel;
      m_watch = 0; m_alive = 0; m_rxclk = 0; m_oe = 0; m_rxd = 1;
      for (int i = 0; i < 3; i++) begin se[i] = 0; sr[i] = 0; end
    end else begin
      n = rat(m_mod); h = n / 2;
      fsk = (m_mod == 3 || m_mod == 4 || m_mod == 5);
      lk = !fsk && (m_tm == 1 || m_tm == 2);
      e = (m_tm == 2) ? (sr[1] && !sr[2]) : (se[1] && !se[2]);
      stp = 1;
      if (lk && e && m_alive != 0) begin
        er = (m_cnt - h + n) % n;
        if (er == 0) stp = 1; else if (er < h) stp = 0; else stp = 2;
      end
      if (!lk) begin m_alive = 0; m_watch = 0; end
      else if (e) begin m_alive = 1; m_watch = 0; end
      else if (m_watch >= 2 * n - 1) m_alive = 0;
      else m_watch++;
      nc = m_cnt + stp; wr = nc >= n; if (wr) nc -= n;
      m_rxclk = (carrier_det && (fsk ? (nc >= h) : sr[1])) ? 1 : 0;
      m_oe = carrier_det; m_rxd = carrier_det ? rx_data_in : 1;
      m_cnt = nc; m_tx = (nc >= h) ? 1 : 0;
      if (wr) begin m_mod = mod_sel; m_tm = tmode_sel; end
      se[2] = se[1]; se[1] = se[0]; se[0] = ext_clk;
      sr[2] = sr[1]; sr[1] = sr[0]; sr[0] = rx_clk_in;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "tx_clk", tx_clk, m_tx);
      chk("R7", "rx_clk_oe", rx_clk_oe, m_oe);
      chk("R7", "rx_clk", rx_clk, m_rxclk);
      chk("R8", "rx_data", rx_data, m_rxd);
    end
  end

  // reference and data generator
  initial forever begin
    @(posedge clk); #2;
    if (g_en) g_ph = (g_ph + 1) % g_per;
    ext_clk   = g_en && g_to_ext  && (g_ph >= g_per / 2);
    rx_clk_in = g_en && !g_to_ext && (g_ph >= g_per / 2);
    rx_data_in = 1'($urandom % 2);
  end

  task automatic run(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  // watchdog
  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int p_rise, p_prev, p_cnt;
  initial begin
    run(4);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "reset tx_clk", tx_clk, 0);
    chk("R9", "reset rx_clk_oe", rx_clk_oe, 0);
    chk("R9", "reset rx_clk", rx_clk, 0);
    chk("R9", "reset rx_data", rx_data, 1);
    run(1);
    // R1: internal period measured directly
    cur_req = "R1";
    p_prev = -1; p_cnt = 0;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (tx_clk && p_rise == 0) begin
        if (p_prev >= 0) begin chk("R1", "qam period", i - p_prev, RQ); p_cnt++; end
        p_prev = i;
      end
      p_rise = tx_clk;
    end
    run(1);
    // R6: selection changes mid period
    cur_req = "R6";
    mod_sel = 3'd1; run(150);
    mod_sel = 3'd2; run(200);
    cur_req = "R1";
    mod_sel = 3'd7; tmode_sel = 2'd3; run(100);
    mod_sel = 3'd6; run(60);
    // R7 / R8 carrier and recovered clock
    carrier_det = 1'b1; g_to_ext = 0; g_per = 20; g_en = 1; run(150);
    carrier_det = 1'b0; run(40);
    carrier_det = 1'b1; run(40);
    // R2: FSK modes ignore timing select and references
    cur_req = "R2";
    g_to_ext = 1; g_per = 13;
    tmode_sel = 2'd1; mod_sel = 3'd3; run(120);
    mod_sel = 3'd4; tmode_sel = 2'd2; run(150);
    mod_sel = 3'd5; run(120);
    // R3: external tracking, then a slightly slow reference
    cur_req = "R3";
    mod_sel = 3'd0; tmode_sel = 2'd1; g_to_ext = 1; g_per = 16; g_ph = 5; run(500);
    g_per = 17; run(500);
    // R4: slave tracking on recovered clock
    cur_req = "R4";
    tmode_sel = 2'd2; g_to_ext = 0; g_per = 16; g_ph = 3; run(500);
    mod_sel = 3'd1; g_per = 32; run(600);
    // R5: reference lost, then regained
    cur_req = "R5";
    g_en = 0; run(300);
    g_en = 1; g_per = 30; run(400);
    carrier_det = 1'b0; run(20);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule